// File: doc/BRIEF.md
# Two-Phase Lithium-Ion Charge Sequencer

This block is the digital control for a constant-current / constant-voltage charge cycle. An external converter measures the cell voltage and the charge current and presents each measurement pair as a code on a valid/ready sample stream. From that stream the sequencer decides the phase. It starts in constant-current (CC) mode. It moves to constant-voltage (CV) mode once the cell has reached the voltage ceiling. It stops once the current has decayed to a small fraction of the current measured when CV began. The analog driver receives a current-setpoint code and a voltage-setpoint code. Two flags report the phase: one shows that CC is over, and the other shows that the charge is complete.

Every threshold test must hold on several samples in a row before the state changes, so one noisy conversion cannot move the sequencer. Charging starts when `enable` rises. Dropping `enable` returns the block to idle from any state. All thresholds are parameters in converter codes. With the defaults, a voltage code of 820 stands for the 4.1 V ceiling (5 mV per code) and a current code of 380 stands for the C/3 level of 38 mA (0.1 mA per code). Termination is at 1/20 (5 %) of the latched entry current.

Top module: `ccv_charge_seq`

## Requirements
- R1: During and right after reset, `chg_state` is 0 (IDLE), both flags are low, and both setpoint codes are 0.
- R2: In IDLE with `enable` high, the state becomes CC (`chg_state`=1) at the next clock edge. Samples taken while in IDLE have no effect on the later run counts.
- R3: In CC, `iset_code` equals the CC current code and `vset_code` equals the CV voltage code. The state stays CC while accepted samples have `samp_vbat` below the CV voltage code. An accepted sample below the threshold restarts the consecutive count.
- R4: In CC, the edge that accepts the 4th consecutive sample with `samp_vbat` >= the CV voltage code (equality counts) moves the state to CV (`chg_state`=2) and raises `phase_cv`.
- R5: The `samp_ibat` of that 4th sample is latched as the CV reference current. In CV, `iset_code` and `vset_code` keep their CC values.
- R6: In CV, the edge that accepts the 4th consecutive sample with `samp_ibat*TERM_DEN <= ref*TERM_NUM` (5 % with the defaults) moves the state to DONE (`chg_state`=3). In DONE, `charge_done` and `phase_cv` are high, `iset_code` is 0 and `vset_code` is the CV voltage code. The state stays DONE while `enable` is high.
- R7: Once in CV, the state never returns to CC, whatever voltage the samples later report.
- R8: When `enable` is low at a clock edge, the state is IDLE after that edge from any state. Both flags and both setpoints are then 0, and all run counts are cleared.
- R9: A cycle with `samp_valid` low neither advances nor breaks a run of qualifying samples.
- R10: `vset_code` never exceeds the maximum voltage code `V_MAX_CODE`.
- R11: `samp_ready` is high in every cycle out of reset. The block never back-pressures the converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Charge request; low forces IDLE |
| samp_valid | input | 1 | A measurement pair is presented |
| samp_ready | output | 1 | Sample accepted; high whenever out of reset |
| samp_vbat | input | VW | Cell voltage code |
| samp_ibat | input | IW | Charge current code |
| chg_state | output | 2 | 0 IDLE, 1 CC, 2 CV, 3 DONE |
| phase_cv | output | 1 | High once CC is over (CV or DONE) |
| charge_done | output | 1 | High in DONE |
| iset_code | output | IW | Current setpoint for the driver |
| vset_code | output | VW | Voltage setpoint for the driver |

## Verification
The voltage ramps are built so that they tell apart a sequencer that switches on the first high sample from one that waits for four. They also tell apart the `>=` test from `>`, because a run sits exactly on the threshold code, and they check whether a low sample truly restarts the run. Valid gaps are placed inside runs to separate "sample count" from "cycle count". In CV, the current sits one code above the 5 % limit, then at the limit, with a break in the run, and a later voltage collapse shows that CV never falls back. A second cycle latches a different entry current, which exposes a fixed termination level. Dropping `enable` in mid-CC, mid-CV and DONE checks the return to idle and that the counts are cleared.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CC   = 2'd1,
    ST_CV   = 2'd2,
    ST_DONE = 2'd3
  } chg_state_e;
endpackage

// File: rtl/chg_run_ctr.sv
// Counts consecutive qualifying samples; pulses hit on the RUN_LEN-th one.
module chg_run_ctr #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic qual,
  output logic hit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;

  assign hit = !clear && step && qual && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || hit) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= qual ? cnt + CW'(1) : '0;
    end
  end
endmodule

// File: rtl/chg_cmp.sv
// Threshold tests on one sample: voltage ceiling and termination ratio.
module chg_cmp #(
  parameter int VW        = 10,
  parameter int IW        = 10,
  parameter int V_CV_CODE = 820,
  parameter int TERM_NUM  = 1,
  parameter int TERM_DEN  = 20
) (
  input  logic [VW-1:0] vbat,
  input  logic [IW-1:0] ibat,
  input  logic [IW-1:0] iref,
  output logic          v_at_ceiling,
  output logic          i_decayed
);
  localparam int PW = IW + 16;
  localparam logic [VW-1:0] VTH  = VW'(V_CV_CODE);
  localparam logic [PW-1:0] KNUM = PW'(TERM_NUM);
  localparam logic [PW-1:0] KDEN = PW'(TERM_DEN);

  logic [PW-1:0] lhs, rhs;

  always_comb begin
    lhs          = PW'(ibat) * KDEN;
    rhs          = PW'(iref) * KNUM;
    v_at_ceiling = (vbat >= VTH);
    i_decayed    = (lhs <= rhs);
  end
endmodule

// File: rtl/chg_setpt.sv
// Decodes the phase into driver setpoints and flags; clamps the voltage code.
module chg_setpt
  import chg_seq_pkg::*;
#(
  parameter int VW         = 10,
  parameter int IW         = 10,
  parameter int V_CV_CODE  = 820,
  parameter int V_MAX_CODE = 820,
  parameter int I_CC_CODE  = 380
) (
  input  chg_state_e    state,
  output logic [IW-1:0] iset,
  output logic [VW-1:0] vset,
  output logic          phase_cv,
  output logic          done
);
  localparam int V_EFF = (V_CV_CODE > V_MAX_CODE) ? V_MAX_CODE : V_CV_CODE;

  always_comb begin
    iset     = '0;
    vset     = '0;
    phase_cv = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_CC: begin
        iset = IW'(I_CC_CODE);
        vset = VW'(V_EFF);
      end
      ST_CV: begin
        iset     = IW'(I_CC_CODE);
        vset     = VW'(V_EFF);
        phase_cv = 1'b1;
      end
      ST_DONE: begin
        vset     = VW'(V_EFF);
        phase_cv = 1'b1;
        done     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ccv_charge_seq.sv
module ccv_charge_seq
  import chg_seq_pkg::*;
#(
  parameter int VW         = 10,
  parameter int IW         = 10,
  parameter int V_CV_CODE  = 820,
  parameter int V_MAX_CODE = 820,
  parameter int I_CC_CODE  = 380,
  parameter int TERM_NUM   = 1,
  parameter int TERM_DEN   = 20,
  parameter int RUN_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          samp_valid,
  output logic          samp_ready,
  input  logic [VW-1:0] samp_vbat,
  input  logic [IW-1:0] samp_ibat,
  output logic [1:0]    chg_state,
  output logic          phase_cv,
  output logic          charge_done,
  output logic [IW-1:0] iset_code,
  output logic [VW-1:0] vset_code
);
  chg_state_e    state, state_nx;
  logic [IW-1:0] iref;
  logic          take;
  logic          v_hi, i_lo;
  logic          cc_hit, cv_hit;
  logic          rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign samp_ready = rdy_q;
  assign take       = samp_valid && samp_ready;

  chg_cmp #(
    .VW(VW), .IW(IW), .V_CV_CODE(V_CV_CODE),
    .TERM_NUM(TERM_NUM), .TERM_DEN(TERM_DEN)
  ) u_cmp (
    .vbat(samp_vbat), .ibat(samp_ibat), .iref(iref),
    .v_at_ceiling(v_hi), .i_decayed(i_lo)
  );

  chg_run_ctr #(.RUN_LEN(RUN_LEN)) u_cc_run (
    .clk(clk), .rst_n(rst_n),
    .clear(!enable || state != ST_CC),
    .step(take), .qual(v_hi), .hit(cc_hit)
  );

  chg_run_ctr #(.RUN_LEN(RUN_LEN)) u_cv_run (
    .clk(clk), .rst_n(rst_n),
    .clear(!enable || state != ST_CV),
    .step(take), .qual(i_lo), .hit(cv_hit)
  );

  always_comb begin
    state_nx = state;
    if (!enable) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: state_nx = ST_CC;
        ST_CC:   if (cc_hit) state_nx = ST_CV;
        ST_CV:   if (cv_hit) state_nx = ST_DONE;
        ST_DONE: state_nx = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      iref  <= '0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_IDLE)           iref <= '0;
      else if (state == ST_CC && cc_hit) iref <= samp_ibat;
    end
  end

  assign chg_state = state;

  chg_setpt #(
    .VW(VW), .IW(IW), .V_CV_CODE(V_CV_CODE),
    .V_MAX_CODE(V_MAX_CODE), .I_CC_CODE(I_CC_CODE)
  ) u_setpt (
    .state(state), .iset(iset_code), .vset(vset_code),
    .phase_cv(phase_cv), .done(charge_done)
  );
endmodule

// File: rtl/ccv_charge_seq_chk.sv
module ccv_charge_seq_chk #(
  parameter int VW         = 10,
  parameter int IW         = 10,
  parameter int V_MAX_CODE = 820
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          samp_ready,
  input logic [1:0]    chg_state,
  input logic          phase_cv,
  input logic          charge_done,
  input logic [IW-1:0] iset_code,
  input logic [VW-1:0] vset_code
);
  assert_idle_after_enable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (chg_state == 2'd0 && !phase_cv && !charge_done && iset_code == '0));

  assert_start_cc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_state == 2'd0 && enable) |=> chg_state == 2'd1);

  assert_phase_rise_from_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_cv) |-> (chg_state == 2'd2 && $past(chg_state) == 2'd1));

  assert_done_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    charge_done |-> (chg_state == 2'd3 && phase_cv && iset_code == '0));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_state == 2'd3 && enable) |=> chg_state == 2'd3);

  assert_no_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_state == 2'd2 |=> chg_state != 2'd1);

  assert_vset_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vset_code <= VW'(V_MAX_CODE));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> samp_ready);
endmodule

bind ccv_charge_seq ccv_charge_seq_chk #(
  .VW(VW), .IW(IW), .V_MAX_CODE(V_MAX_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .samp_ready(samp_ready),
  .chg_state(chg_state), .phase_cv(phase_cv), .charge_done(charge_done),
  .iset_code(iset_code), .vset_code(vset_code)
);

// File: tb/sim_ccv_charge_seq.sv
`timescale 1ns/1ps
module sim_ccv_charge_seq;
  localparam int VW = 10, IW = 10;
  localparam int VCV = 820, ICC = 380, TN = 1, TD = 20, RUN = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, samp_valid = 1'b0;
  logic [VW-1:0] samp_vbat = '0;
  logic [IW-1:0] samp_ibat = '0;
  logic samp_ready, phase_cv, charge_done;
  logic [1:0] chg_state;
  logic [IW-1:0] iset_code;
  logic [VW-1:0] vset_code;

  always #10 clk = ~clk;

  ccv_charge_seq u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .samp_valid(samp_valid),
    .samp_ready(samp_ready), .samp_vbat(samp_vbat), .samp_ibat(samp_ibat),
    .chg_state(chg_state), .phase_cv(phase_cv), .charge_done(charge_done),
    .iset_code(iset_code), .vset_code(vset_code)
  );

  int total = 0, bad = 0;
  int mst = 0, run = 0, iref = 0;
  string tag = "R1";
  bit finished = 0;

  task automatic chk(input string rq, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int ei, ev;
    ei = (mst == 1 || mst == 2) ? ICC : 0;
    ev = (mst == 0) ? 0 : VCV;
    chk(tag, chg_state, mst, "state");
    chk(tag, phase_cv, (mst >= 2) ? 1 : 0, "phase_cv");
    chk(tag, charge_done, (mst == 3) ? 1 : 0, "charge_done");
    chk(tag, iset_code, ei, "iset_code");
    chk(tag, vset_code, ev, "vset_code");
    chk("R11", samp_ready, 1, "samp_ready");
  endtask

  // Reference: run counts measured in accepted samples only.
  task automatic model(input bit en, input bit v, input int vb, input int ib);
    if (!en) begin
      mst = 0; run = 0; iref = 0;
    end else begin
      case (mst)
        0: begin mst = 1; run = 0; end
        1: if (v) begin
             if (vb >= VCV) run++; else run = 0;
             if (run == RUN) begin mst = 2; iref = ib; run = 0; end
           end
        2: if (v) begin
             if (ib * TD <= iref * TN) run++; else run = 0;
             if (run == RUN) begin mst = 3; run = 0; end
           end
        default: ;
      endcase
    end
  endtask

  // Called at a negedge: drive, clock, update model, compare at next negedge.
  task automatic step(input bit en, input bit v, input int vb, input int ib);
    enable = en; samp_valid = v; samp_vbat = VW'(vb); samp_ibat = IW'(ib);
    @(posedge clk);
    model(en, v, vb, ib);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", chg_state, 0, "state in reset");
    chk("R1", iset_code, 0, "iset in reset");
    chk("R1", vset_code, 0, "vset in reset");
    chk("R1", phase_cv + charge_done, 0, "flags in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R8/R2: samples while idle and disabled are ignored
    tag = "R8";
    for (int k = 0; k < 4; k++) step(0, 1, 900, 10);
    chk("R8", chg_state, 0, "idle with enable low");
    tag = "R2";
    step(1, 1, 900, 10);
    chk("R2", chg_state, 1, "enter CC");

    // R3: below threshold, then a broken run
    tag = "R3";
    for (int k = 0; k < 5; k++) step(1, 1, 800 + 4 * k, 380);
    step(1, 1, 820, 380); step(1, 1, 825, 380); step(1, 1, 830, 380);
    step(1, 1, 819, 380);
    chk("R3", chg_state, 1, "low sample restarts run");
    chk("R3", iset_code, ICC, "CC current setpoint");

    // R9/R4: run of four at exactly the threshold with gaps
    tag = "R9";
    step(1, 1, 820, 370); step(1, 0, 0, 0); step(1, 1, 820, 375);
    step(1, 0, 500, 0); step(1, 1, 820, 378);
    chk("R9", chg_state, 1, "three of four, still CC");
    tag = "R4";
    step(1, 1, 820, 380);
    chk("R4", chg_state, 2, "enter CV on 4th sample");
    chk("R4", phase_cv, 1, "phase flag");
    chk("R5", iset_code, ICC, "CV keeps current limit");

    // R7/R6: CV with voltage collapse, termination at ref/20 = 19
    tag = "R7";
    for (int k = 0; k < 3; k++) step(1, 1, 700, 200);
    chk("R7", chg_state, 2, "no fall back to CC");
    tag = "R6";
    step(1, 1, 820, 20); step(1, 1, 820, 19); step(1, 1, 820, 19);
    step(1, 1, 820, 19); step(1, 1, 820, 20);
    chk("R6", chg_state, 2, "run broken above 5 percent");
    step(1, 1, 820, 19); step(1, 0, 0, 0); step(1, 1, 820, 5);
    step(1, 1, 820, 0);
    chk("R6", charge_done, 0, "three of four");
    step(1, 1, 820, 19);
    chk("R6", chg_state, 3, "enter DONE");
    chk("R6", iset_code, 0, "DONE current zero");
    for (int k = 0; k < 3; k++) step(1, 1, 500, 300);
    chk("R6", charge_done, 1, "DONE held");

    tag = "R8";
    step(0, 0, 0, 0);
    chk("R8", chg_state, 0, "DONE to IDLE");

    // R5: second cycle, reference 100 -> limit 5
    tag = "R5";
    step(1, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(1, 1, 830, 100);
    chk("R5", chg_state, 2, "CV again");
    for (int k = 0; k < 4; k++) step(1, 1, 830, 6);
    chk("R5", chg_state, 2, "6 above new limit");
    for (int k = 0; k < 3; k++) step(1, 1, 830, 5);
    tag = "R8";
    step(0, 1, 830, 5);
    chk("R8", chg_state, 0, "CV to IDLE");
    step(1, 0, 0, 0);
    step(1, 1, 830, 100);
    chk("R8", chg_state, 1, "count cleared, still CC");
    step(1, 1, 830, 100); step(1, 1, 830, 100);
    step(0, 1, 830, 100);
    step(1, 1, 830, 100);
    step(1, 1, 830, 100); step(1, 1, 830, 100); step(1, 1, 830, 100);
    chk("R8", chg_state, 1, "CC run cleared by enable drop");
    step(1, 1, 830, 100);
    chk("R4", chg_state, 2, "fresh run completes");
    chk("R10", (vset_code <= VCV) ? 1 : 0, 1, "vset ceiling");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule